// File: doc/BRIEF.md
# Four-Player Quiz Buzzer Controller

This block referees a four-contestant quiz round. Each contestant has an active-low push button. The buttons are brought into the clock domain through a synchronizer. The first registered press wins and lights that contestant's lamp. The winner is also reported as a small numeric code, and a short press beep sounds. All later presses are ignored until the host pulls the active-low clear.

Winning a press also starts an answer timer. The timer counts down from 99 to 00 in two BCD digits, one step per one-second tick enable. When it runs out, a timeout warning comes on and stays on. The winner code and both timer digits share one seven-segment output. A free-running select counter time-multiplexes them onto that output.

Top module: `quiz_buzzer`

## Requirements
- R1: While `rstN` is low, and right after it is released: `lamps` is 0000, `winnerCode` is 15, `buzzer` and `timeUp` are 0, `tens` and `units` are both 9, and `scanSel` is 0.
- R2: A button held low passes through a two-flop synchronizer. The lamp of that player (bit 0 = player 1 … bit 3 = player 4) turns on at the third rising clock edge after the button goes low, and not before.
- R3: Once a lamp is on, no further button activity changes `lamps` or `winnerCode` until a clear.
- R4: When several buttons are seen pressed on the same clock edge, only the lowest-numbered player's lamp turns on.
- R5: `winnerCode` is the player number (1 to 4) of the lit lamp. When no lamp is lit it is 15.
- R6: While no lamp is lit, both timer digits stay at 9 and `tick` has no effect. After the lock, each clock edge with `tick` high lowers the two-digit value by one. A tick on the same edge as the lock is ignored.
- R7: The digits are BCD. When `units` is 0 and `tens` is not 0, a tick sets `units` to 9 and lowers `tens` by one.
- R8: At 00 the timer stays at 00. `timeUp` rises one clock after the value reaches 00 and stays high until clear.
- R9: `buzzer` is high from the lock edge until BEEP_TICKS further ticks have been counted (default 3). It is also high whenever `timeUp` is high.
- R10: `scanSel` advances by one every clock, wrapping from 7 to 0. The displayed code is `winnerCode` at select 0, `tens` at select 1, `units` at select 7, and 15 at every other select value.
- R11: `segments` is active-high in bit order g..a (bit 6 = g, bit 0 = a). Digits 0–9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 27, 7F, 6F (hex). Any other code gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Host clear, active low, asynchronous |
| tick | input | 1 | One-cycle one-second enable |
| btnN | input | 4 | Contestant buttons, active low, bit 0 = player 1 |
| lamps | output | 4 | One-hot winner lamp |
| winnerCode | output | 4 | Winner number 1–4, or 15 when none |
| buzzer | output | 1 | Press beep or timeout warning |
| timeUp | output | 1 | Answer time expired |
| tens | output | 4 | Countdown tens digit, BCD |
| units | output | 4 | Countdown units digit, BCD |
| scanSel | output | 3 | Display select |
| segments | output | 7 | Seven-segment drive, g..a, active high |

## Verification
Two events can share one clock edge: the edge that latches the winner, and a one-second tick. The bench raises `tick` for exactly the edge at which the synchronized press arrives. It then checks that the timer still shows 99 and that the beep has its full length, measured over the following ticks. A second collision comes from several buttons pressed together. All fifteen non-empty button patterns are applied at once, and the lit lamp must be the lowest-numbered pressed player.

// File: rtl/quiz_buzzer_pkg.sv
`timescale 1ns/1ps
package quiz_buzzer_pkg;
  localparam int PLAYERS = 4;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;
  localparam int SEL_W   = 3;
  localparam logic [DIGIT_W-1:0] CODE_NONE = 4'hF;

  typedef struct packed {
    logic run;   // a winner is latched, timer may count
    logic step;  // decrement on this edge
  } timerCtl_t;

  // active-low pattern with a single low bit -> player number
  function automatic logic [DIGIT_W-1:0] encodeWinner(input logic [PLAYERS-1:0] patN);
    case (patN)
      4'b1110: encodeWinner = 4'd1;
      4'b1101: encodeWinner = 4'd2;
      4'b1011: encodeWinner = 4'd3;
      4'b0111: encodeWinner = 4'd4;
      default: encodeWinner = CODE_NONE;
    endcase
  endfunction

  function automatic logic [SEG_W-1:0] segOf(input logic [DIGIT_W-1:0] d);
    case (d)
      4'd0: segOf = 7'h3F;
      4'd1: segOf = 7'h06;
      4'd2: segOf = 7'h5B;
      4'd3: segOf = 7'h4F;
      4'd4: segOf = 7'h66;
      4'd5: segOf = 7'h6D;
      4'd6: segOf = 7'h7D;
      4'd7: segOf = 7'h27;
      4'd8: segOf = 7'h7F;
      4'd9: segOf = 7'h6F;
      default: segOf = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/quiz_ctrl.sv
`timescale 1ns/1ps
module quiz_ctrl
  import quiz_buzzer_pkg::*;
#(
  parameter int BEEP_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [PLAYERS-1:0] btnN,
  output logic [PLAYERS-1:0] lamps,
  output logic               beep,
  output timerCtl_t          timerCtl
);
  localparam int BEEP_W = $clog2(BEEP_TICKS + 1);

  logic [SYNC_STAGES-1:0][PLAYERS-1:0] syncN;
  logic [PLAYERS-1:0] pressed;
  logic [PLAYERS-1:0] grant;
  logic [BEEP_W-1:0]  beepCnt;
  logic               locked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncN <= '1;
    end else begin
      syncN[0] <= btnN;
      for (int s = 1; s < SYNC_STAGES; s++) syncN[s] <= syncN[s-1];
    end
  end

  assign pressed = ~syncN[SYNC_STAGES-1];
  assign locked  = |lamps;

  // lowest-numbered pressed player wins a tie
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int p = 0; p < PLAYERS; p++) begin
      if (pressed[p] && !found) begin
        grant[p] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lamps   <= '0;
      beepCnt <= '0;
    end else if (!locked && |pressed) begin
      lamps   <= grant;
      beepCnt <= BEEP_W'(BEEP_TICKS);
    end else if (tick && beepCnt != '0) begin
      beepCnt <= beepCnt - 1'b1;
    end
  end

  assign beep          = beepCnt != '0;
  assign timerCtl.run  = locked;
  assign timerCtl.step = locked && tick;
endmodule

// File: rtl/quiz_datapath.sv
`timescale 1ns/1ps
module quiz_datapath
  import quiz_buzzer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  timerCtl_t          timerCtl,
  input  logic [PLAYERS-1:0] lamps,
  output logic [DIGIT_W-1:0] tens,
  output logic [DIGIT_W-1:0] units,
  output logic               timeUp,
  output logic [DIGIT_W-1:0] winnerCode,
  output logic [SEL_W-1:0]   scanSel,
  output logic [SEG_W-1:0]   segments
);
  logic               atZero;
  logic [DIGIT_W-1:0] shownCode;

  assign atZero = (tens == '0) && (units == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tens   <= 4'd9;
      units  <= 4'd9;
      timeUp <= 1'b0;
    end else if (!timerCtl.run) begin
      tens   <= 4'd9;
      units  <= 4'd9;
      timeUp <= 1'b0;
    end else begin
      if (atZero) timeUp <= 1'b1;
      if (timerCtl.step && !atZero) begin
        if (units == '0) begin
          units <= 4'd9;
          tens  <= tens - 1'b1;
        end else begin
          units <= units - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scanSel <= '0;
    else       scanSel <= scanSel + 1'b1;
  end

  assign winnerCode = encodeWinner(~lamps);

  always_comb begin
    case (scanSel)
      3'd0:    shownCode = winnerCode;
      3'd1:    shownCode = tens;
      3'd7:    shownCode = units;
      default: shownCode = CODE_NONE;
    endcase
  end

  assign segments = segOf(shownCode);
endmodule

// File: rtl/quiz_buzzer.sv
`timescale 1ns/1ps
module quiz_buzzer
  import quiz_buzzer_pkg::*;
#(
  parameter int BEEP_TICKS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic [3:0]  btnN,
  output logic [3:0]  lamps,
  output logic [3:0]  winnerCode,
  output logic        buzzer,
  output logic        timeUp,
  output logic [3:0]  tens,
  output logic [3:0]  units,
  output logic [2:0]  scanSel,
  output logic [6:0]  segments
);
  timerCtl_t timerCtl;
  logic      beep;

  quiz_ctrl #(.BEEP_TICKS(BEEP_TICKS), .SYNC_STAGES(2)) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .btnN(btnN),
    .lamps(lamps), .beep(beep), .timerCtl(timerCtl)
  );

  quiz_datapath dpath (
    .clk(clk), .rstN(rstN), .timerCtl(timerCtl), .lamps(lamps),
    .tens(tens), .units(units), .timeUp(timeUp),
    .winnerCode(winnerCode), .scanSel(scanSel), .segments(segments)
  );

  assign buzzer = beep | timeUp;
endmodule

// File: rtl/quiz_buzzer_checker.sv
`timescale 1ns/1ps
module quiz_buzzer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic [3:0] lamps,
  input logic       buzzer,
  input logic       timeUp,
  input logic [3:0] tens,
  input logic [3:0] units,
  input logic [2:0] scanSel,
  input logic [6:0] segments
);
  a_r2_lamp_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lamps));

  a_r3_lamps_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (lamps != 4'd0) |=> (lamps == $past(lamps)));

  a_r6_idle_reload: assert property (@(posedge clk) disable iff (!rstN)
    (lamps == 4'd0) |-> (tens == 4'd9 && units == 4'd9));

  a_r6_no_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (lamps != 4'd0 && !tick) |=> $stable({tens, units}));

  a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rstN)
    timeUp |=> timeUp);

  a_r8_zero_held: assert property (@(posedge clk) disable iff (!rstN)
    timeUp |-> (tens == 4'd0 && units == 4'd0));

  a_r9_warning_sounds: assert property (@(posedge clk) disable iff (!rstN)
    timeUp |-> buzzer);

  a_r10_scan_advance: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (scanSel == $past(scanSel) + 3'd1));

  a_r11_unused_blank: assert property (@(posedge clk) disable iff (!rstN)
    (scanSel inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6}) |-> (segments == 7'h00));
endmodule

bind quiz_buzzer quiz_buzzer_checker chk (
  .clk(clk), .rstN(rstN), .tick(tick), .lamps(lamps), .buzzer(buzzer),
  .timeUp(timeUp), .tens(tens), .units(units), .scanSel(scanSel),
  .segments(segments)
);

// File: tb/quiz_buzzer_test.sv
`timescale 1ns/1ps
module quiz_buzzer_test;
  localparam int BEEP = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] btnN = 4'hF;
  logic [3:0] lamps, winnerCode, tens, units;
  logic       buzzer, timeUp;
  logic [2:0] scanSel;
  logic [6:0] segments;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  quiz_buzzer #(.BEEP_TICKS(BEEP)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .btnN(btnN), .lamps(lamps),
    .winnerCode(winnerCode), .buzzer(buzzer), .timeUp(timeUp),
    .tens(tens), .units(units), .scanSel(scanSel), .segments(segments)
  );

  function automatic int expSeg(input int d);
    case (d)
      0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
      4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h27;
      8: return 'h7F; 9: return 'h6F;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearUnit();
    @(negedge clk);
    btnN = 4'hF;
    tick = 1'b0;
    rstN = 1'b0;
    step();
    rstN = 1'b1;
  endtask

  task automatic checkIdle(input string tag);
    chk({tag, " lamps"}, lamps, 0);
    chk({tag, " code"}, winnerCode, 15);
    chk({tag, " buzzer"}, buzzer, 0);
    chk({tag, " timeUp"}, timeUp, 0);
    chk({tag, " tens"}, tens, 9);
    chk({tag, " units"}, units, 9);
  endtask

  // R10 R11: one full scan period, expected segments per select
  task automatic scanSweep(input int win, input int t, input int u);
    int prev;
    prev = scanSel;
    for (int c = 0; c < 8; c++) begin
      int code;
      step();
      chk("R10 scan advance", scanSel, (prev + 1) % 8);
      prev = scanSel;
      case (scanSel)
        0: code = win;
        1: code = t;
        7: code = u;
        default: code = 15;
      endcase
      chk("R11 segment pattern", segments, expSeg(code));
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    checkIdle("R1 in clear");
    chk("R1 scan reset", scanSel, 0);
    rstN = 1'b1;
    scanSweep(15, 9, 9);

    // R11 decoder over all codes via units digit is limited; check winner codes
    // R2 R5 R3: each player alone, with latency and lockout
    for (int p = 0; p < 4; p++) begin
      clearUnit();
      btnN = ~(4'b1 << p);
      step();
      step();
      chk("R2 no lamp before third edge", lamps, 0);
      step();
      chk("R2 lamp lit", lamps, 1 << p);
      chk("R5 winner code", winnerCode, p + 1);
      chk("R9 press beep", buzzer, 1);
      btnN = 4'h0;
      step(); step(); step(); step();
      chk("R3 lamps locked", lamps, 1 << p);
      chk("R3 code locked", winnerCode, p + 1);
      scanSweep(p + 1, 9, 9);
    end

    // R4: every simultaneous press pattern
    for (int pat = 1; pat < 16; pat++) begin
      int low;
      low = 0;
      while (((pat >> low) & 1) == 0) low++;
      clearUnit();
      btnN = ~pat[3:0];
      step(); step(); step();
      chk("R4 lowest wins", lamps, 1 << low);
      chk("R5 tie code", winnerCode, low + 1);
    end

    // R6: ticks before any press do nothing
    clearUnit();
    for (int k = 0; k < 5; k++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
      step();
    end
    chk("R6 idle tens", tens, 9);
    chk("R6 idle units", units, 9);

    // R6 R9: tick coincides with lock edge (player 3)
    btnN = 4'b1011;
    step(); step();
    tick = 1'b1;
    step();
    tick = 1'b0;
    chk("R6 lock-edge tick ignored tens", tens, 9);
    chk("R6 lock-edge tick ignored units", units, 9);
    chk("R9 beep on lock", buzzer, 1);
    btnN = 4'hF;

    // R6 R7 R9: full countdown
    for (int k = 1; k <= 99; k++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
      chk("R7 tens digit", tens, (99 - k) / 10);
      chk("R7 units digit", units, (99 - k) % 10);
      chk("R9 beep length", buzzer, (k < BEEP) ? 1 : 0);
      chk("R8 no early timeout", timeUp, 0);
      step();
      chk("R6 hold between ticks", units, (99 - k) % 10);
    end
    chk("R8 timeUp one clock after 00", timeUp, 1);
    chk("R9 warning buzzer", buzzer, 1);
    for (int k = 0; k < 3; k++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
      step();
    end
    chk("R8 stays tens", tens, 0);
    chk("R8 stays units", units, 0);
    chk("R8 timeUp held", timeUp, 1);
    scanSweep(3, 0, 0);

    // R1: clear in the middle of a timeout
    @(negedge clk);
    rstN = 1'b0;
    #3;
    checkIdle("R1 mid-run clear");
    step();
    rstN = 1'b1;
    checkIdle("R1 after release");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule